// File: doc/BRIEF.md
# TDM Serial Audio Slave Port

This block is the serial side of a multichannel audio port that works as a slave. An external master supplies the bit clock and the frame sync. The block runs directly on the bit clock. A frame starts when frame sync goes high. Frame sync may then stay high for any number of bit clocks, from one up to one fewer than the frame length. The first bit of slot 0 is sampled on the second bit-clock rising edge after frame sync rises.

Each slot is `SLOT_W` bits wide and carries a sample most significant bit first. The sample occupies the upper `DATA_W` bits of the slot.
- On the receive side, the first `RX_CH` slots of the input line are shifted in. They are handed over as parallel words, together with a one-cycle strobe.
- On the transmit side, `TX_CH` parallel words are captured at frame start. They are shifted out on the falling bit-clock edge.

The frame holds `SLOTS*SLOT_W` bit clocks, or twice that in long-frame mode. Long frames are refused when double-speed is selected. A frame-sync edge that arrives after the wrong number of bit clocks raises a sticky error flag, and the slot count restarts from that edge.

Top module: `tdm_slave_port`

## Requirements
- R1: While `rst_n` is low, `sdout`, `rx_valid`, `frame_err` and `rx_words` are all zero. After reset, `sdout` stays low until the first rising edge of `fsync` has been seen.
- R2: Slot 0's MSB is taken on the second `sck` rising edge after `fsync` rises. Each following `sck` rising edge takes the next bit. Channel c is `rx_words[c*DATA_W +: DATA_W]` and holds bits `SLOT_W-1` down to `SLOT_W-DATA_W` of slot c.
- R3: `rx_valid` is high for exactly one `sck` cycle per frame. That cycle follows the rising edge that captures the last bit of slot `RX_CH-1`, and `rx_words` is updated on the same edge.
- R4: `sdout` changes only on falling `sck` edges. Slot c (c < `TX_CH`) carries `tx_words[c*DATA_W +: DATA_W]`, MSB first, in its first `DATA_W` bit times. The remaining bit times of the slot are zero.
- R5: `tx_words` is captured on the rising edge that detects the frame start. Changes to `tx_words` later in the frame do not affect that frame.
- R6: Only the rising edge of `fsync` marks a frame. Any pulse width from 1 to frame length minus 1 bit clocks gives the same behaviour.
- R7: If a rising edge of `fsync` arrives after a bit-clock count different from the configured frame length, `frame_err` goes high. It stays high until reset. Slot counting restarts from that new edge, so the following frame is received correctly.
- R8: With `long_frame`=1 and `dbl_speed`=0, the frame is `2*SLOTS*SLOT_W` bit clocks long. Slots beyond the active channels drive `sdout` low and their input bits are ignored.
- R9: With `long_frame`=1 and `dbl_speed`=1, `cfg_reject` is high and the frame length stays `SLOTS*SLOT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Bit clock from the master |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; its rising edge starts a frame |
| sdin | input | 1 | Serial data in, sampled on rising `sck` |
| sdout | output | 1 | Serial data out, updated on falling `sck` |
| long_frame | input | 1 | 1 selects the double frame length |
| dbl_speed | input | 1 | Double-speed rate; forbids the long frame |
| cfg_reject | output | 1 | Long frame requested at double speed |
| tx_words | input | TX_CH*DATA_W | Transmit samples, channel 0 in the low bits |
| rx_words | output | RX_CH*DATA_W | Received samples, channel 0 in the low bits |
| rx_valid | output | 1 | One-cycle strobe when `rx_words` is updated |
| frame_err | output | 1 | Sticky frame-length mismatch flag |

## Verification
The bench builds the port with its default parameters: 32-bit slots, 8 slots, 4 receive and 4 transmit channels, and 24-bit samples. With these values the receive window ends at bit 127, so the strobe position, the zero padding inside each slot and the idle slots 4 to 7 (or 4 to 15) all fall within a 256 or 512 bit-clock frame. The 512-clock frames, the rejected double-speed setting and a deliberately short 200-clock frame can therefore all be driven. Each of them is compared against a behavioural model, bit time by bit time.

// File: rtl/tdm_slave_port.sv
`timescale 1ns/1ps
module tdm_slave_port #(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8,
  parameter int RX_CH  = 4,
  parameter int TX_CH  = 4,
  parameter int DATA_W = 24
) (
  input  logic                    sck,
  input  logic                    rst_n,
  input  logic                    fsync,
  input  logic                    sdin,
  output logic                    sdout,
  input  logic                    long_frame,
  input  logic                    dbl_speed,
  output logic                    cfg_reject,
  input  logic [TX_CH*DATA_W-1:0] tx_words,
  output logic [RX_CH*DATA_W-1:0] rx_words,
  output logic                    rx_valid,
  output logic                    frame_err
);
  localparam int BASE_LEN = SLOTS * SLOT_W;
  localparam int MAX_LEN  = 2 * BASE_LEN;
  localparam int CW       = $clog2(MAX_LEN) + 1;
  localparam int SW       = $clog2(SLOT_W);
  localparam int RX_BITS  = RX_CH * SLOT_W;
  localparam int TX_BITS  = TX_CH * SLOT_W;

  logic                    fs_q, synced, tx_bit;
  logic [CW-1:0]           bcnt;
  logic [RX_BITS-1:0]      rx_sh;
  logic [TX_CH*DATA_W-1:0] tx_lat;

  wire               fs_rise   = fsync & ~fs_q;
  wire  [CW-1:0]     frame_len = (long_frame & ~dbl_speed) ? CW'(MAX_LEN) : CW'(BASE_LEN);
  wire  [RX_BITS-1:0] rx_full  = {rx_sh[RX_BITS-2:0], sdin};
  wire               capture   = synced & ~fs_rise & (bcnt < CW'(RX_BITS));
  wire               last_rx   = capture & (bcnt == CW'(RX_BITS-1));
  wire  [CW-SW-1:0]  tslot     = bcnt[CW-1:SW];
  wire  [SW-1:0]     tpos      = bcnt[SW-1:0];

  assign cfg_reject = long_frame & dbl_speed;

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      synced    <= 1'b0;
      bcnt      <= '0;
      rx_sh     <= '0;
      tx_lat    <= '0;
      rx_words  <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      fs_q     <= fsync;
      rx_valid <= last_rx;
      if (fs_rise) begin
        synced <= 1'b1;
        bcnt   <= '0;
        tx_lat <= tx_words;
        if (synced && bcnt != frame_len - CW'(1)) frame_err <= 1'b1;
      end else if (synced && bcnt != '1) begin
        bcnt <= bcnt + CW'(1);
      end
      if (capture) rx_sh <= rx_full;
      if (last_rx)
        for (int c = 0; c < RX_CH; c++)
          rx_words[c*DATA_W +: DATA_W] <= rx_full[RX_BITS-1-c*SLOT_W -: DATA_W];
    end
  end

  always_comb begin
    tx_bit = 1'b0;
    if (synced && bcnt < CW'(TX_BITS) && tpos < SW'(DATA_W))
      tx_bit = tx_lat[int'(tslot)*DATA_W + DATA_W - 1 - int'(tpos)];
  end

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) sdout <= 1'b0;
    else        sdout <= tx_bit;
  end
endmodule

module tdm_slave_port_chk #(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8,
  parameter int RX_CH  = 4,
  parameter int CW     = 10
) (
  input logic          sck,
  input logic          rst_n,
  input logic          sdout,
  input logic          rx_valid,
  input logic          frame_err,
  input logic          synced,
  input logic          cfg_reject,
  input logic [CW-1:0] bcnt,
  input logic [CW-1:0] frame_len
);
  assert_quiet_R1: assert property (@(posedge sck) disable iff (!rst_n)
    !synced |-> !sdout);
  assert_slot_pos_R2: assert property (@(posedge sck) disable iff (!rst_n)
    rx_valid |-> $past(bcnt) == CW'(RX_CH*SLOT_W - 1));
  assert_one_pulse_R3: assert property (@(posedge sck) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_sticky_R7: assert property (@(posedge sck) disable iff (!rst_n)
    frame_err |=> frame_err);
  assert_base_len_R9: assert property (@(posedge sck) disable iff (!rst_n)
    cfg_reject |-> frame_len == CW'(SLOTS*SLOT_W));
endmodule

bind tdm_slave_port tdm_slave_port_chk #(
  .SLOT_W(SLOT_W), .SLOTS(SLOTS), .RX_CH(RX_CH), .CW(CW)
) u_chk (
  .sck(sck), .rst_n(rst_n), .sdout(sdout), .rx_valid(rx_valid),
  .frame_err(frame_err), .synced(synced), .cfg_reject(cfg_reject),
  .bcnt(bcnt), .frame_len(frame_len)
);

// File: tb/sim_tdm_slave_port.sv
`timescale 1ns/1ps
module sim_tdm_slave_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0, sdin = 1'b0;
  logic        long_frame = 1'b0, dbl_speed = 1'b0;
  logic [95:0] tx_words = '0;
  logic        sdout, cfg_reject, rx_valid, frame_err;
  logic [95:0] rx_words;

  always #2.5 clk = ~clk;

  tdm_slave_port u0 (
    .sck(clk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin), .sdout(sdout),
    .long_frame(long_frame), .dbl_speed(dbl_speed), .cfg_reject(cfg_reject),
    .tx_words(tx_words), .rx_words(rx_words), .rx_valid(rx_valid), .frame_err(frame_err)
  );

  int n_chk = 0, n_bad = 0;
  logic exp_err = 1'b0;
  int cur_len = 256, prev_len = 0;
  bit have_prev = 0;
  logic [31:0] rxs[4];
  logic [23:0] txw[4];

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic txbit(int b);
    int slot = b / 32;
    int pos = b % 32;
    if (slot < 4 && pos < 24) return txw[slot][23-pos];
    return 1'b0;
  endfunction

  function automatic logic [95:0] pack_tx();
    logic [95:0] v;
    for (int c = 0; c < 4; c++) v[c*24 +: 24] = txw[c];
    return v;
  endfunction

  function automatic logic [95:0] exp_rx();
    logic [95:0] v;
    for (int c = 0; c < 4; c++) v[c*24 +: 24] = rxs[c][31:8];
    return v;
  endfunction

  task automatic do_reset(bit lf, bit ds);
    rst_n = 1'b0; fsync = 1'b0; long_frame = lf; dbl_speed = ds;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 sdout in reset", {95'd0, sdout}, 96'd0);
    chk("R1 rx_valid in reset", {95'd0, rx_valid}, 96'd0);
    chk("R1 frame_err in reset", {95'd0, frame_err}, 96'd0);
    chk("R1 rx_words in reset", rx_words, 96'd0);
    rst_n = 1'b1;
    tx_words = '1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1; sdin = 1'($urandom); #1;
      chk("R1 sdout before first frame", {95'd0, sdout}, 96'd0);
    end
    have_prev = 0; exp_err = 1'b0;
    cur_len = (lf && !ds) ? 512 : 256;
  endtask

  task automatic run_frame(int len, int fsw, bit nl, bit nd, bit mid_change);
    string tag;
    for (int c = 0; c < 4; c++) begin
      rxs[c] = $urandom;
      txw[c] = 24'($urandom);
    end
    if (have_prev && prev_len != cur_len) exp_err = 1'b1;
    tag = mid_change ? "R5" : (len == 512 ? "R8" : "R4");
    for (int j = 0; j < len; j++) begin
      @(negedge clk); #1;
      fsync = (j < fsw);
      if (j >= 1 && j - 1 < 128) sdin = rxs[(j-1)/32][31-((j-1)%32)];
      else sdin = 1'($urandom);
      if (j == 0) tx_words = pack_tx();
      if (j == 1) begin long_frame = nl; dbl_speed = nd; end
      if (mid_change && j == 60) tx_words = ~pack_tx();
      #1;
      chk($sformatf("%s sdout bit %0d", tag, j), {95'd0, sdout},
          {95'd0, (j == 0) ? 1'b0 : txbit(j-1)});
      chk("R3 rx_valid strobe", {95'd0, rx_valid}, {95'd0, (j == 129)});
      if (j == 129) chk(fsw > 1 ? "R6 rx_words" : "R2 rx_words", rx_words, exp_rx());
      if (j == 1) chk("R7 frame_err", {95'd0, frame_err}, {95'd0, exp_err});
      if (j == 2) chk("R9 cfg_reject", {95'd0, cfg_reject}, {95'd0, nl & nd});
    end
    have_prev = 1; prev_len = len;
    cur_len = (nl && !nd) ? 512 : 256;
  endtask

  initial begin
    do_reset(0, 0);
    run_frame(256, 1, 0, 0, 0);
    run_frame(256, 100, 0, 0, 0);
    run_frame(256, 255, 0, 0, 0);
    run_frame(256, 32, 0, 0, 1);
    run_frame(256, 8, 1, 1, 0);
    run_frame(256, 8, 1, 1, 0);
    run_frame(512, 300, 1, 0, 0);
    run_frame(512, 511, 1, 0, 0);
    run_frame(256, 8, 0, 0, 0);
    run_frame(256, 8, 0, 0, 0);
    run_frame(200, 10, 0, 0, 0);
    run_frame(256, 10, 0, 0, 0);
    run_frame(256, 3, 0, 0, 0);
    do_reset(0, 0);
    run_frame(256, 1, 0, 0, 0);
    run_frame(256, 1, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule